// File: doc/BRIEF.md
# Shadow Return-Address Stack Checker

This block sits next to a processor's branch unit and keeps a private, hardware-only copy of return addresses. Each call that links (direct or register branch-with-link, or a trap into a runtime helper) pushes the address of the instruction after the call. Each return compares the live return target with the newest stored entry and raises a one-cycle fault strobe with a cause code when the stored entry is malformed or the two disagree. Software may also push a value explicitly, pop the newest entry explicitly, and ask whether checking is active through a query word.

The check is lenient by design. A zero stored entry, which includes an empty stack, is never checked and never removed. A zero return target is accepted against any aligned entry. Any checked entry is removed whether or not it faulted. When checking is disabled the stack is still maintained, but no fault is ever raised. A stack of parameterised depth backs the store. A push onto a full stack is dropped and reported as an overflow.

In one cycle the block performs at most one removal, then at most one insertion. A return takes the removal slot ahead of an explicit pop, and a call takes the insertion slot ahead of an explicit push. A link-and-return branch therefore checks the old top before its new link address lands.

Top module: `retaddr_guard`

## Requirements
- R1: A call with `call_vld` high pushes `call_link`. Entries come back in last-in-first-out order through explicit pops.
- R2: A return whose top entry is zero (stack empty, or a stored zero) raises no fault and removes nothing.
- R3: A return whose non-zero top entry has bits [1:0] not both zero raises cause 1 (misaligned), even when the target equals the entry. The entry is removed.
- R4: A return with an aligned non-zero top raises cause 2 (mismatch) only when the target is non-zero and differs from the entry. Targets that are zero or equal raise no fault. The entry is removed in every case.
- R5: An explicit pop loads `pop_data` with the top entry at the clock edge and removes it. On an empty stack it loads zero and leaves the stack empty.
- R6: When a return and a call come in the same cycle, the return is checked against the old top, then the call's link is pushed.
- R7: `query_out` equals `query_in` with bit 0 cleared while `chk_en` is high, and equals `query_in` unchanged while `chk_en` is low. This output is combinational.
- R8: While `chk_en` is low, no fault is raised. Pushes, pops and return removals still take effect.
- R9: An insertion onto a stack holding DEPTH entries, with no removal in the same cycle, is dropped and raises cause 3 (overflow). The stored entries are left unchanged.
- R10: `fault_vld` and `fault_cause` are registered and describe the operation of the previous cycle. `fault_vld` is high for exactly that one cycle. The cause is 0 whenever there is no fault.
- R11: A return takes precedence over an explicit pop in the same cycle, and the pop is not performed. A call takes precedence over an explicit push in the same cycle, and the push is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en | input | 1 | Checking enabled |
| call_vld | input | 1 | Call-with-link strobe |
| call_link | input | 64 | Address after the call |
| ret_vld | input | 1 | Return strobe |
| ret_tgt | input | 64 | Live return target |
| push_vld | input | 1 | Explicit push request |
| push_data | input | 64 | Value to push |
| pop_vld | input | 1 | Explicit pop request |
| pop_data | output | 64 | Value of the last served explicit pop |
| query_in | input | 64 | Feature query word |
| query_out | output | 64 | Query result |
| fault_vld | output | 1 | One-cycle fault strobe |
| fault_cause | output | 2 | 0 none, 1 misaligned, 2 mismatch, 3 overflow |

## Verification
Some effects can only be seen later through other ports, and these are the hardest to observe. Examples are a zero entry that must survive a return, a return that must remove a faulting entry, and a dropped push on a full stack. The stimulus first builds a known stack contents, for instance a non-zero entry below a zero entry. It then issues the return and drains the stack with explicit pops, so the values that come out show what stayed behind. Combined-cycle cases work the same way: return plus call, return plus pop, and call plus push. Each is followed by pops that reveal which operation won.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

  localparam int unsigned ADDR_W = 64;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_MISALIGN = 2'd1,
    CAUSE_MISMATCH = 2'd2,
    CAUSE_OVERFLOW = 2'd3
  } cause_e;

  // Classify a return against the stored top entry.
  function automatic cause_e classify_return(logic [ADDR_W-1:0] top,
                                             logic [ADDR_W-1:0] tgt);
    cause_e c;
    if (top == '0)                          c = CAUSE_NONE;
    else if (top[1:0] != 2'b00)             c = CAUSE_MISALIGN;
    else if ((tgt != '0) && (tgt != top))   c = CAUSE_MISMATCH;
    else                                    c = CAUSE_NONE;
    return c;
  endfunction

  // A stored entry takes part in a check only when it is non-zero.
  function automatic logic entry_checked(logic [ADDR_W-1:0] top);
    return top != '0;
  endfunction

  // Feature query: bit 0 is cleared to signal that checking is active.
  function automatic logic [ADDR_W-1:0] query_word(logic [ADDR_W-1:0] w,
                                                   logic en);
    logic [ADDR_W-1:0] mask;
    mask = {{(ADDR_W-1){1'b1}}, ~en};
    return w & mask;
  endfunction

endpackage

// File: rtl/rsg_store.sv
module rsg_store
  import rsg_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rm_req,
  input  logic              ins_req,
  input  logic [ADDR_W-1:0] ins_data,
  output logic [ADDR_W-1:0] top,
  output logic              rm_taken,
  output logic              ins_taken,
  output logic              ins_drop,
  output logic [$clog2(DEPTH+1)-1:0] cnt
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [ADDR_W-1:0] mem [DEPTH];
  logic              empty;
  logic [CNT_W-1:0]  cnt_mid;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [PTR_W-1:0]  rd_idx;
  logic [PTR_W-1:0]  wr_idx;

  assign empty  = (cnt == '0);
  assign rd_idx = PTR_W'(cnt - ONE);
  assign top    = empty ? '0 : mem[rd_idx];

  // Removal phase, then insertion phase.
  assign rm_taken  = rm_req && !empty;
  assign cnt_mid   = rm_taken ? (cnt - ONE) : cnt;
  assign ins_taken = ins_req && (cnt_mid < FULL_CNT);
  assign ins_drop  = ins_req && !ins_taken;
  assign wr_idx    = PTR_W'(cnt_mid);
  assign cnt_nxt   = ins_taken ? (cnt_mid + ONE) : cnt_mid;

  always_ff @(posedge clk) begin
    if (ins_taken) mem[wr_idx] <= ins_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);

  assert_empty_pop_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_req && empty && !ins_req) |=> (cnt == '0));

  assert_full_drop_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ins_drop |=> (cnt == FULL_CNT));

endmodule

// File: rtl/rsg_ret_check.sv
module rsg_ret_check
  import rsg_pkg::*;
(
  input  logic              ret_req,
  input  logic [ADDR_W-1:0] top,
  input  logic [ADDR_W-1:0] tgt,
  output logic              ret_remove,
  output cause_e            ret_cause
);

  always_comb begin
    ret_remove = 1'b0;
    ret_cause  = CAUSE_NONE;
    if (ret_req) begin
      ret_remove = entry_checked(top);
      ret_cause  = classify_return(top, tgt);
    end
  end

endmodule

// File: rtl/rsg_query.sv
module rsg_query
  import rsg_pkg::*;
(
  input  logic              en,
  input  logic [ADDR_W-1:0] word_in,
  output logic [ADDR_W-1:0] word_out
);

  assign word_out = query_word(word_in, en);

  always_comb begin
    assert_query_high_bits_R7: assert (word_out[ADDR_W-1:1] == word_in[ADDR_W-1:1]);
  end

endmodule

// File: rtl/retaddr_guard.sv
module retaddr_guard
  import rsg_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en,
  input  logic              call_vld,
  input  logic [63:0]       call_link,
  input  logic              ret_vld,
  input  logic [63:0]       ret_tgt,
  input  logic              push_vld,
  input  logic [63:0]       push_data,
  input  logic              pop_vld,
  output logic [63:0]       pop_data,
  input  logic [63:0]       query_in,
  output logic [63:0]       query_out,
  output logic              fault_vld,
  output logic [1:0]        fault_cause
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  // Named internal events.
  logic              rm_req;
  logic              ins_req;
  logic [ADDR_W-1:0] ins_data;
  logic [ADDR_W-1:0] top;
  logic              rm_taken;
  logic              ins_taken;
  logic              ins_drop;
  logic [CNT_W-1:0]  cnt;
  logic              ret_remove;
  cause_e            ret_cause;
  logic              pop_served;
  cause_e            cause_nxt;
  cause_e            cause_q;
  logic              vld_q;
  logic [ADDR_W-1:0] pop_q;

  rsg_ret_check u_check (
    .ret_req    (ret_vld),
    .top        (top),
    .tgt        (ret_tgt),
    .ret_remove (ret_remove),
    .ret_cause  (ret_cause)
  );

  // Return owns the removal slot; call owns the insertion slot.
  assign pop_served = pop_vld && !ret_vld;
  assign rm_req     = ret_vld ? ret_remove : pop_vld;
  assign ins_req    = call_vld || push_vld;
  assign ins_data   = call_vld ? call_link : push_data;

  rsg_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rm_req    (rm_req),
    .ins_req   (ins_req),
    .ins_data  (ins_data),
    .top       (top),
    .rm_taken  (rm_taken),
    .ins_taken (ins_taken),
    .ins_drop  (ins_drop),
    .cnt       (cnt)
  );

  rsg_query u_query (
    .en       (chk_en),
    .word_in  (query_in),
    .word_out (query_out)
  );

  always_comb begin
    cause_nxt = CAUSE_NONE;
    if (chk_en) begin
      if (ret_cause != CAUSE_NONE) cause_nxt = ret_cause;
      else if (ins_drop)           cause_nxt = CAUSE_OVERFLOW;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= CAUSE_NONE;
      vld_q   <= 1'b0;
      pop_q   <= '0;
    end else begin
      cause_q <= cause_nxt;
      vld_q   <= (cause_nxt != CAUSE_NONE);
      if (pop_served) pop_q <= top;
    end
  end

  assign fault_vld   = vld_q;
  assign fault_cause = cause_q;
  assign pop_data    = pop_q;

  assert_disabled_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |=> !fault_vld);

  assert_zero_top_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && (top == '0)) |=>
      (cnt == $past(cnt) + CNT_W'($past(ins_taken))));

  assert_checked_removed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && (top != '0)) |=>
      (cnt == $past(cnt) - CNT_W'(1) + CNT_W'($past(ins_taken))));

  assert_pop_blocked_by_ret_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && pop_vld) |=> $stable(pop_data));

  assert_strobe_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_vld == (fault_cause != 2'd0)));

endmodule

// File: tb/tb_retaddr_guard.sv
`timescale 1ns/1ps
module tb_retaddr_guard;

  localparam int unsigned DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        chk_en, call_vld, ret_vld, push_vld, pop_vld;
  logic [63:0] call_link, ret_tgt, push_data, query_in;
  logic [63:0] pop_data, query_out;
  logic        fault_vld;
  logic [1:0]  fault_cause;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  retaddr_guard #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en),
    .call_vld(call_vld), .call_link(call_link),
    .ret_vld(ret_vld), .ret_tgt(ret_tgt),
    .push_vld(push_vld), .push_data(push_data),
    .pop_vld(pop_vld), .pop_data(pop_data),
    .query_in(query_in), .query_out(query_out),
    .fault_vld(fault_vld), .fault_cause(fault_cause)
  );

  typedef struct packed {
    logic        en;
    logic        call;
    logic        ret;
    logic        push;
    logic        pop;
    logic [63:0] d;
    logic [63:0] t;
    logic [1:0]  ef;
    logic        chk;
    logic [63:0] ep;
    logic [3:0]  rq;
  } vec_t;

  localparam logic Y = 1'b1;
  localparam logic N = 1'b0;
  localparam int NV = 37;

  // Fields: en call ret push pop data target exp_fault check_pop exp_pop req
  localparam vec_t VT [NV] = '{
    '{Y,Y,N,N,N,64'h100,64'h0,  2'd0,N,64'h0,  4'd1},  // R1 call
    '{Y,Y,N,N,N,64'h200,64'h0,  2'd0,N,64'h0,  4'd1},  // R1 call
    '{Y,N,Y,N,N,64'h0,  64'h200,2'd0,N,64'h0,  4'd4},  // R4 equal target
    '{Y,N,Y,N,N,64'h0,  64'h300,2'd2,N,64'h0,  4'd4},  // R4 mismatch
    '{Y,N,Y,N,N,64'h0,  64'h500,2'd0,N,64'h0,  4'd2},  // R2 empty stack
    '{Y,N,N,Y,N,64'h103,64'h0,  2'd0,N,64'h0,  4'd3},
    '{Y,N,Y,N,N,64'h0,  64'h103,2'd1,N,64'h0,  4'd3},  // R3 misaligned
    '{Y,N,N,N,Y,64'h0,  64'h0,  2'd0,Y,64'h0,  4'd3},  // R3 entry removed
    '{Y,N,N,Y,N,64'h400,64'h0,  2'd0,N,64'h0,  4'd4},
    '{Y,N,Y,N,N,64'h0,  64'h0,  2'd0,N,64'h0,  4'd4},  // R4 zero target
    '{Y,N,N,N,Y,64'h0,  64'h0,  2'd0,Y,64'h0,  4'd4},  // R4 removed
    '{Y,N,N,Y,N,64'h40, 64'h0,  2'd0,N,64'h0,  4'd2},
    '{Y,N,N,Y,N,64'h0,  64'h0,  2'd0,N,64'h0,  4'd2},  // stored zero
    '{Y,N,Y,N,N,64'h0,  64'h700,2'd0,N,64'h0,  4'd2},  // R2 no check
    '{Y,N,N,N,Y,64'h0,  64'h0,  2'd0,Y,64'h0,  4'd2},  // R2 zero still there
    '{Y,N,N,N,Y,64'h0,  64'h0,  2'd0,Y,64'h40, 4'd2},
    '{Y,N,N,Y,N,64'h800,64'h0,  2'd0,N,64'h0,  4'd6},
    '{Y,Y,Y,N,N,64'h900,64'h800,2'd0,N,64'h0,  4'd6},  // R6 ret then call
    '{Y,N,N,N,Y,64'h0,  64'h0,  2'd0,Y,64'h900,4'd6},
    '{Y,N,N,N,Y,64'h0,  64'h0,  2'd0,Y,64'h0,  4'd5},  // R5 empty pop
    '{Y,N,N,Y,N,64'h800,64'h0,  2'd0,N,64'h0,  4'd6},
    '{Y,Y,Y,N,N,64'h904,64'h808,2'd2,N,64'h0,  4'd6},  // R6 old top checked
    '{Y,N,N,N,Y,64'h0,  64'h0,  2'd0,Y,64'h904,4'd6},
    '{N,N,N,Y,N,64'h10, 64'h0,  2'd0,N,64'h0,  4'd8},
    '{N,N,Y,N,N,64'h0,  64'h20, 2'd0,N,64'h0,  4'd8},  // R8 silent
    '{Y,N,N,N,Y,64'h0,  64'h0,  2'd0,Y,64'h0,  4'd8},  // R8 still removed
    '{Y,N,N,Y,N,64'h30, 64'h0,  2'd0,N,64'h0,  4'd11},
    '{Y,N,N,Y,N,64'h34, 64'h0,  2'd0,N,64'h0,  4'd11},
    '{Y,N,Y,N,Y,64'h0,  64'h34, 2'd0,N,64'h0,  4'd11}, // R11 pop ignored
    '{Y,N,N,N,Y,64'h0,  64'h0,  2'd0,Y,64'h30, 4'd11},
    '{Y,Y,N,Y,N,64'h50, 64'h0,  2'd0,N,64'h0,  4'd11}, // R11 push discarded
    '{Y,N,N,N,Y,64'h0,  64'h0,  2'd0,Y,64'h50, 4'd11},
    '{Y,N,N,N,Y,64'h0,  64'h0,  2'd0,Y,64'h0,  4'd11},
    '{Y,Y,N,N,N,64'hA0, 64'h0,  2'd0,N,64'h0,  4'd1},
    '{Y,Y,N,N,N,64'hB0, 64'h0,  2'd0,N,64'h0,  4'd1},
    '{Y,N,N,N,Y,64'h0,  64'h0,  2'd0,Y,64'hB0, 4'd1},  // R1 LIFO
    '{Y,N,N,N,Y,64'h0,  64'h0,  2'd0,Y,64'hA0, 4'd1}
  };

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    call_vld = 0; ret_vld = 0; push_vld = 0; pop_vld = 0;
    call_link = '0; ret_tgt = '0; push_data = '0;
  endtask

  task automatic run_vec(vec_t v);
    string tag;
    @(negedge clk);
    chk_en = v.en; call_vld = v.call; ret_vld = v.ret;
    push_vld = v.push; pop_vld = v.pop;
    call_link = v.d; push_data = v.d; ret_tgt = v.t;
    @(negedge clk);
    idle_inputs();
    tag = $sformatf("R%0d", v.rq);
    check64({tag, " fault_cause"}, {62'd0, fault_cause}, {62'd0, v.ef});
    check64({tag, " fault_vld R10"}, {63'd0, fault_vld}, {63'd0, v.ef != 2'd0});
    if (v.chk) check64({tag, " pop_data"}, pop_data, v.ep);
  endtask

  task automatic op_push(logic [63:0] val);
    @(negedge clk);
    push_vld = 1; push_data = val;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic op_pop();
    @(negedge clk);
    pop_vld = 1;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; chk_en = 1; query_in = '0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // Reset state (R10, R5)
    check64("R10 reset fault_vld", {63'd0, fault_vld}, 64'd0);
    check64("R10 reset fault_cause", {62'd0, fault_cause}, 64'd0);
    check64("R5 reset pop_data", pop_data, 64'd0);

    // Query word (R7)
    chk_en = 1; query_in = 64'h0123456789abcdef; #1;
    check64("R7 enabled clears bit0", query_out, 64'h0123456789abcdee);
    query_in = 64'hfffffffffffffffe; #1;
    check64("R7 bit0 already clear", query_out, 64'hfffffffffffffffe);
    chk_en = 0; query_in = 64'h0123456789abcdef; #1;
    check64("R7 disabled unchanged", query_out, 64'h0123456789abcdef);
    chk_en = 1;

    for (int i = 0; i < NV; i++) run_vec(VT[i]);

    // Overflow (R9): fill DEPTH entries, then one more insertion.
    for (int k = 0; k < DEPTH; k++) op_push(64'h1000 + 64'(4 * k));
    @(negedge clk);
    push_vld = 1; push_data = 64'h2000;
    @(negedge clk);
    idle_inputs();
    check64("R9 overflow cause", {62'd0, fault_cause}, 64'd3);
    check64("R9 overflow strobe", {63'd0, fault_vld}, 64'd1);
    @(negedge clk);
    check64("R10 strobe one cycle", {63'd0, fault_vld}, 64'd0);
    check64("R10 cause back to none", {62'd0, fault_cause}, 64'd0);
    // Call onto full stack also overflows; disabled one is silent.
    @(negedge clk);
    call_vld = 1; call_link = 64'h3000;
    @(negedge clk);
    idle_inputs();
    check64("R9 call overflow cause", {62'd0, fault_cause}, 64'd3);
    @(negedge clk);
    chk_en = 0; push_vld = 1; push_data = 64'h4000;
    @(negedge clk);
    idle_inputs(); chk_en = 1;
    check64("R8 disabled overflow silent", {63'd0, fault_vld}, 64'd0);
    op_pop();
    check64("R9 dropped write, top kept", pop_data, 64'h100c);
    for (int k = DEPTH - 2; k >= 0; k--) begin
      op_pop();
      check64("R9 lower entries intact", pop_data, 64'h1000 + 64'(4 * k));
    end
    op_pop();
    check64("R5 drained stack pops zero", pop_data, 64'd0);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule